// File: doc/BRIEF.md
# Comma word aligner

This block sits behind a deserializer that delivers forty encoded line bits per clock, four 10-bit symbols, which becomes 32 data bits after decoding. The word clock therefore runs at the line rate divided by forty. The deserializer starts at an arbitrary bit phase. The block finds the K28.5 comma symbol in the incoming bit stream and picks a bit offset so that every comma lands in symbol slot 0 of the word it emits. From then on, the 32-bit data boundaries line up with the transmitter's.

The search covers the previous raw word joined with the current one. A comma that straddles two raw words is therefore found at any of the forty possible bit offsets. The two running-disparity forms of the comma are detected separately, and each form has its own enable. Either form alone can set the alignment.

A one-cycle pulse marks each change of offset. A later comma of the other form at the same offset changes nothing. 8b/10b decoding, elastic buffering, lane bonding and clock recovery are left to other blocks.

Top module: `comma_word_aligner`

## Requirements
- R1: While `rst_ni` is low, `data_o` is zero and `aligned_o`, `realign_o`, `comma_pos_o` and `comma_neg_o` are low. The offset returns to 0, and the stored previous word is cleared to zero.
- R2: After each rising edge, `data_o` holds bits [off+39:off] of the 80-bit window {current `raw_i`, previous `raw_i`}. `off` is the offset in force for that word, which is 0 before any comma. Output therefore lags the input by one register stage.
- R3: Each 10-bit symbol carries its first-received bit in bit 0. The negative-disparity comma is the value 10'h17C in that order (line bits 0011111010). When `en_neg_i` is high and this value sits at window bits [k+9:k] for some k in 0..39, `comma_neg_o` is high after that edge and slot 0 (`data_o[9:0]`) of the same output word holds the comma.
- R4: The positive-disparity comma is 10'h283, the bitwise complement of 10'h17C. When `en_pos_i` is high it is detected, flagged on `comma_pos_o` and aligned in the same way as in R3.
- R5: Commas are found at every bit offset 0..39, including ones that cross the raw word boundary. When several enabled matches fall in one window, the lowest offset is taken.
- R6: `realign_o` is high for exactly the one output word in which a detected comma gives an offset different from the one in force. The first comma after reset always counts as a change.
- R7: A comma of the other disparity found at the offset already in force leaves the offset unchanged and raises no `realign_o` pulse. Its own detection flag still rises.
- R8: A comma form whose enable is low is ignored. Its flag stays low, and the offset, `aligned_o` and `data_o` behave as if the comma were absent.
- R9: `aligned_o` is low from reset until the first detected comma. It then stays high until reset, including across later realignments.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_pos_i | input | 1 | Enables detection of the positive-disparity comma |
| en_neg_i | input | 1 | Enables detection of the negative-disparity comma |
| raw_i | input | 40 | Raw deserialized word, first-received symbol in bits [9:0] |
| data_o | output | 40 | Aligned word, comma position in bits [9:0] |
| aligned_o | output | 1 | An alignment has been established since reset |
| realign_o | output | 1 | One-word pulse on an offset change |
| comma_pos_o | output | 1 | Positive-disparity comma found in this window |
| comma_neg_o | output | 1 | Negative-disparity comma found in this window |

## Verification
Every result of this block is due exactly one rising edge after the raw word that produces it. This holds for the aligned word, the polarity flags, the realign pulse and the rise of the aligned flag, because a single register stage holds all of them. The bench changes `raw_i` on a falling edge, lets one rising edge pass, and reads the outputs on the following falling edge. The expected words are cut from a bench-built bit stream at the bit position that the comma's location and the deserializer phase predict. Before alignment, the expectation is the previous raw word, since the offset is 0 and the window's lower half is the stored word.

// File: rtl/aligner_pkg.sv
package aligner_pkg;

    // one encoded symbol; the comma patterns are fixed at this width
    localparam int SYM_W = 10;

    // first-received bit in bit 0
    localparam logic [SYM_W-1:0] COMMA_NEG = 10'h17C;
    localparam logic [SYM_W-1:0] COMMA_POS = ~COMMA_NEG;

endpackage

// File: rtl/comma_scan.sv
module comma_scan #(
    parameter int                 WORD_W = 40,
    parameter int                 SYM_W  = 10,
    parameter logic [SYM_W-1:0]   PAT    = '0
) (
    input  logic [WORD_W+SYM_W-2:0] win_i,
    output logic [WORD_W-1:0]       hit_o
);

    // one comparator per bit offset
    for (genvar g = 0; g < WORD_W; g++) begin : g_off
        assign hit_o[g] = (win_i[g +: SYM_W] == PAT);
    end

endmodule

// File: rtl/offset_pick.sv
module offset_pick #(
    parameter int WORD_W = 40,
    localparam int OFF_W = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] hit_i,
    output logic              found_o,
    output logic [OFF_W-1:0]  idx_o
);

    // lowest offset wins
    always_comb begin
        found_o = |hit_i;
        idx_o   = '0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (hit_i[i]) begin
                idx_o = OFF_W'(i);
            end
        end
    end

endmodule

// File: rtl/word_shift.sv
module word_shift #(
    parameter int WORD_W = 40,
    localparam int OFF_W = $clog2(WORD_W)
) (
    input  logic [2*WORD_W-2:0] win_i,
    input  logic [OFF_W-1:0]    sel_i,
    output logic [WORD_W-1:0]   word_o
);

    logic [WORD_W-1:0] cand [WORD_W];

    for (genvar g = 0; g < WORD_W; g++) begin : g_cand
        assign cand[g] = win_i[g +: WORD_W];
    end

    always_comb begin
        word_o = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (sel_i == OFF_W'(i)) begin
                word_o = cand[i];
            end
        end
    end

endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner
    import aligner_pkg::*;
#(
    parameter int SYM_CNT = 4,
    localparam int WORD_W = SYM_CNT * SYM_W,
    localparam int OFF_W  = $clog2(WORD_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_pos_i,
    input  logic              en_neg_i,
    input  logic [WORD_W-1:0] raw_i,
    output logic [WORD_W-1:0] data_o,
    output logic              aligned_o,
    output logic              realign_o,
    output logic              comma_pos_o,
    output logic              comma_neg_o
);

    typedef struct packed {
        logic [WORD_W-1:0] prev;
        logic [WORD_W-1:0] dout;
        logic [OFF_W-1:0]  off;
        logic              aligned;
        logic              realign;
        logic              seen_pos;
        logic              seen_neg;
    } state_t;

    state_t st_d, st_q;

    logic [WORD_W-1:0] hit_pos, hit_neg, hit_all;
    logic              found;
    logic [OFF_W-1:0]  idx;
    logic [OFF_W-1:0]  sel;
    logic [WORD_W-1:0] shifted;

    comma_scan #(.WORD_W(WORD_W), .SYM_W(SYM_W), .PAT(COMMA_POS)) u_scan_pos (
        .win_i ({raw_i[SYM_W-2:0], st_q.prev}),
        .hit_o (hit_pos)
    );

    comma_scan #(.WORD_W(WORD_W), .SYM_W(SYM_W), .PAT(COMMA_NEG)) u_scan_neg (
        .win_i ({raw_i[SYM_W-2:0], st_q.prev}),
        .hit_o (hit_neg)
    );

    assign hit_all = (hit_pos & {WORD_W{en_pos_i}}) | (hit_neg & {WORD_W{en_neg_i}});

    offset_pick #(.WORD_W(WORD_W)) u_pick (
        .hit_i   (hit_all),
        .found_o (found),
        .idx_o   (idx)
    );

    assign sel = found ? idx : st_q.off;

    word_shift #(.WORD_W(WORD_W)) u_shift (
        .win_i  ({raw_i[WORD_W-2:0], st_q.prev}),
        .sel_i  (sel),
        .word_o (shifted)
    );

    always_comb begin
        st_d          = st_q;
        st_d.prev     = raw_i;
        st_d.dout     = shifted;
        st_d.seen_pos = en_pos_i && (|hit_pos);
        st_d.seen_neg = en_neg_i && (|hit_neg);
        st_d.realign  = found && (!st_q.aligned || (idx != st_q.off));
        if (found) begin
            st_d.off     = idx;
            st_d.aligned = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o      = st_q.dout;
    assign aligned_o   = st_q.aligned;
    assign realign_o   = st_q.realign;
    assign comma_pos_o = st_q.seen_pos;
    assign comma_neg_o = st_q.seen_neg;

endmodule

// File: rtl/aligner_checks.sv
module aligner_checks (
    input logic clk_i,
    input logic rst_ni,
    input logic en_pos_i,
    input logic en_neg_i,
    input logic aligned_o,
    input logic realign_o,
    input logic comma_pos_o,
    input logic comma_neg_o
);

    p_first_lock_pulses_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(aligned_o) |-> realign_o);

    p_pulse_needs_comma_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        realign_o |-> (comma_pos_o || comma_neg_o));

    p_pulse_implies_lock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        realign_o |-> aligned_o);

    p_lock_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        aligned_o |=> aligned_o);

    p_pos_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(en_pos_i) |-> !comma_pos_o);

    p_neg_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(en_neg_i) |-> !comma_neg_o);

endmodule

bind comma_word_aligner aligner_checks u_checks (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_pos_i    (en_pos_i),
    .en_neg_i    (en_neg_i),
    .aligned_o   (aligned_o),
    .realign_o   (realign_o),
    .comma_pos_o (comma_pos_o),
    .comma_neg_o (comma_neg_o)
);

// File: tb/sim_comma_word_aligner.sv
module sim_comma_word_aligner;

    localparam logic [9:0] NEG  = 10'h17C;
    localparam logic [9:0] POS  = 10'h283;
    localparam logic [9:0] FILL = 10'h155;

    // {phase[5:0], positive, en_pos, en_neg}
    localparam logic [8:0] VEC [8] = '{
        {6'd0,  1'b0, 1'b1, 1'b1},
        {6'd5,  1'b1, 1'b1, 1'b1},
        {6'd13, 1'b0, 1'b0, 1'b1},
        {6'd27, 1'b1, 1'b1, 1'b0},
        {6'd39, 1'b0, 1'b1, 1'b1},
        {6'd31, 1'b1, 1'b0, 1'b1},
        {6'd22, 1'b0, 1'b1, 1'b0},
        {6'd1,  1'b1, 1'b1, 1'b1}
    };

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        en_pos_i = 1'b1;
    logic        en_neg_i = 1'b1;
    logic [39:0] raw_i = '0;
    logic [39:0] data_o;
    logic        aligned_o, realign_o, comma_pos_o, comma_neg_o;

    int checks = 0;
    int fails  = 0;
    logic [9:0] syms [64];

    always #5ns clk_i = ~clk_i;

    comma_word_aligner u0 (
        .clk_i, .rst_ni, .en_pos_i, .en_neg_i, .raw_i,
        .data_o, .aligned_o, .realign_o, .comma_pos_o, .comma_neg_o
    );

    task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [39:0] span(input int start);
        logic [39:0] v;
        for (int b = 0; b < 40; b++) begin
            v[b] = syms[(start + b) / 10][(start + b) % 10];
        end
        return v;
    endfunction

    task automatic fill_all();
        for (int i = 0; i < 64; i++) syms[i] = FILL;
    endtask

    task automatic do_reset();
        @(negedge clk_i);
        rst_ni = 1'b0;
        raw_i  = '0;
        @(negedge clk_i);
        rst_ni = 1'b1;
    endtask

    task automatic step(input logic [39:0] w);
        raw_i = w;
        @(posedge clk_i);
        @(negedge clk_i);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #1ms;
        fails++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        // R1: reset state
        @(negedge clk_i);
        chk("R1 data", data_o, '0);
        chk("R1 aligned", 40'(aligned_o), 40'd0);
        chk("R1 realign", 40'(realign_o), 40'd0);
        chk("R1 flags", 40'({comma_pos_o, comma_neg_o}), 40'd0);

        // table: one comma at symbol 8 under varied phases and enables (R2..R9)
        for (int v = 0; v < 8; v++) begin
            int  s, nd;
            bit  pol, ep, en, det;
            s   = int'(VEC[v][8:3]);
            pol = VEC[v][2];
            ep  = VEC[v][1];
            en  = VEC[v][0];
            det = pol ? ep : en;
            nd  = (80 - s) / 40 + 1;
            fill_all();
            syms[8] = pol ? POS : NEG;
            en_pos_i = ep;
            en_neg_i = en;
            do_reset();
            for (int n = 0; n < 6; n++) begin
                logic [39:0] exp_d;
                bit hit_now;
                hit_now = det && (n == nd);
                step(span(40 * n + s));
                if (det && n >= nd) exp_d = span(80 + 40 * (n - nd));
                else if (n == 0)    exp_d = '0;
                else                exp_d = span(40 * (n - 1) + s);
                chk(det ? "R2 R5 data" : "R8 data", data_o, exp_d);
                chk(det ? "R9 aligned" : "R8 aligned", 40'(aligned_o), 40'(det && n >= nd));
                chk("R6 realign", 40'(realign_o), 40'(hit_now));
                chk(pol ? "R4 pos flag" : "R8 pos flag", 40'(comma_pos_o), 40'(hit_now && pol));
                chk(pol ? "R8 neg flag" : "R3 neg flag", 40'(comma_neg_o), 40'(hit_now && !pol));
            end
        end

        // R7: negative comma then positive comma at the same offset
        fill_all();
        syms[8]  = NEG;
        syms[16] = POS;
        en_pos_i = 1'b1;
        en_neg_i = 1'b1;
        do_reset();
        for (int n = 0; n < 7; n++) begin
            step(span(40 * n));
            if (n == 3) chk("R3 neg lock", 40'({realign_o, comma_neg_o}), 40'b11);
            if (n == 5) begin
                chk("R7 no pulse", 40'(realign_o), 40'd0);
                chk("R7 pos seen", 40'(comma_pos_o), 40'd1);
                chk("R7 aligned", 40'(aligned_o), 40'd1);
                chk("R7 slot0", 40'(data_o[9:0]), 40'(POS));
            end
        end

        // R6: second comma at a new offset pulses again
        fill_all();
        syms[8]  = NEG;
        syms[13] = NEG;
        do_reset();
        for (int n = 0; n < 6; n++) begin
            step(span(40 * n));
            if (n == 3) chk("R6 first pulse", 40'(realign_o), 40'd1);
            if (n == 4) begin
                chk("R6 second pulse", 40'(realign_o), 40'd1);
                chk("R5 shifted word", data_o, span(130));
                chk("R9 stays aligned", 40'(aligned_o), 40'd1);
            end
            if (n == 5) begin
                chk("R6 single cycle", 40'(realign_o), 40'd0);
                chk("R2 after shift", data_o, span(170));
            end
        end

        // R1/R9: reset while aligned clears the lock
        rst_ni = 1'b0;
        #1ns;
        chk("R1 mid reset aligned", 40'(aligned_o), 40'd0);
        chk("R1 mid reset data", data_o, '0);
        @(negedge clk_i);
        rst_ni = 1'b1;
        step(span(0));
        chk("R9 low after reset", 40'(aligned_o), 40'd0);

        finish_up();
    end

endmodule